// File: doc/BRIEF.md
# Edge-Sensed Vectored Interrupt Controller

This block collects interrupt requests from fourteen sources and presents one of them to the CPU as a vector number. Four external pins each pass through a two-flop synchronizer and an edge detector that is set to rising or falling edges. One auxiliary external channel can sense rising, falling or both edges. Its input comes either from its pin or from an internal PWM output. Nine peripheral request lines complete the set. Each source has a sticky request flag and a recognition enable. A global mask bit holds off every source at once.

The highest-priority request that is pending, enabled and not masked is placed on a valid/ready style output. `irq_valid` is the valid signal, `irq_vector` is the payload and `irq_ack` acts as ready. After the controller raises valid, the vector stays constant until the CPU acknowledges it, however long that takes. This holds even if software clears the flag or changes the mask meanwhile. An acknowledge sets the global mask, so a second request cannot be offered until software clears the mask again. The acknowledge leaves the source's flag set. Software reaches all settings over a simple register bus: a write strobe, an address and write data, with read data returned combinationally.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the following read back as 0: register 0, register 1, register 2 and register 3. Register 4 (the mask) reads 1 and `irq_valid` is 0.
- R2: Register 0 bits 3:0 set the edge for external pins 0..3: 1 selects rising and 0 selects falling. A pin's flag is set on the selected edge only while its bit in register 1 (pin function, bits 3:0) is 1.
- R3: Register 0 bits 5:4 set the auxiliary edge mode: 00 is falling, 01 is rising, and 10 or 11 is both edges. The auxiliary flag is set only while its source enable (register 2 bit 2) is 1.
- R4: Register 0 bit 6 selects the auxiliary input: 0 takes `aux_pin` and 1 takes `aux_pwm`.
- R5: A high on `periph_req[j]` at a clock edge sets the flag for internal source j.
- R6: Flags live in register 3. Source index order is 0: pin0, 1: pin1, 2: aux, 3: pin2, 4: pin3, and 5..13: `periph_req[0..8]`. Writing 0 to a flag bit clears it and writing 1 has no effect. If a set and a clear meet in the same cycle, the flag stays set.
- R7: A flagged source is offered only when its enable bit in register 2 is 1 and the mask (register 4 bit 0) is 0.
- R8: The vectors are 4, 5, 6, 7 and 8 for source indices 0..4, 11..16 for indices 5..10, and 18..20 for indices 11..13. When several sources qualify, the lowest vector wins.
- R9: Once `irq_valid` is 1, it and `irq_vector` hold until a cycle with `irq_ack` high. That acknowledge sets the mask to 1 and drops valid at the next edge, and it leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 4 | External interrupt pins 0..3 |
| aux_pin | input | 1 | Auxiliary channel pin |
| aux_pwm | input | 1 | Internal PWM output usable as auxiliary input |
| periph_req | input | 9 | Peripheral request lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address 0..4 |
| bus_wdata | input | 14 | Register write data |
| bus_rdata | output | 14 | Read data for `bus_addr` |
| irq_valid | output | 1 | A vector is being offered |
| irq_vector | output | 5 | Offered vector number |
| irq_ack | input | 1 | CPU accepts the offered vector |

## Verification
A pin change that is driven before clock edge 1 sets its flag at edge 3, because two synchronizer flops and an edge register sit on the path. `irq_valid` then rises at edge 4. A peripheral request line sets its flag at edge 1, and valid follows at edge 2. A write to the mask or to the enables takes effect at its own edge, and valid follows one edge later. An acknowledge drops valid and sets the mask at the edge on which it is sampled. The bench drives all inputs at falling edges, waits six cycles after any source stimulus and one to three cycles after any register write or acknowledge, and samples only at falling edges, so every result is read after its last register has settled.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_EXT  = 4;
  localparam int NUM_INT  = 9;
  localparam int NUM_SRC  = NUM_EXT + 1 + NUM_INT;
  localparam int VEC_W    = 5;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int AUX_IDX  = 2;
  localparam int INT_BASE = NUM_EXT + 1;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // external pin number to source index (aux channel sits at index 2)
  function automatic int ext_to_src(input int pin);
    return (pin < AUX_IDX) ? pin : pin + 1;
  endfunction

  // source index to vector number
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    if (idx < IDX_W'(INT_BASE))          return VEC_W'(idx + 4);
    else if (idx < IDX_W'(INT_BASE + 6)) return VEC_W'(idx + 6);
    else                                 return VEC_W'(idx + 7);
  endfunction
endpackage

// File: rtl/irq_edge_sense.sv
module irq_edge_sense #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] mode,   // 00 fall, 01 rise, 1x both
  output logic       pulse
);
  logic [STAGES:0] sh_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];
  assign pulse = mode[1] ? (rise | fall) : (mode[0] ? rise : fall);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set,
  input  logic     wr_en,
  input  src_vec_t wr_data,
  output src_vec_t flags
);
  src_vec_t clr;

  assign clr = wr_en ? ~wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end

  // R6: a flag drops only where a clear was written
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags) & ~$past(clr)) & ~flags) == '0);
  // R5: every set request is captured
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(set) & ~flags) == '0);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  src_vec_t         req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_EXT-1:0]   ext_pin,
  input  logic                 aux_pin,
  input  logic                 aux_pwm,
  input  logic [NUM_INT-1:0]   periph_req,
  input  logic                 bus_we,
  input  logic [2:0]           bus_addr,
  input  logic [NUM_SRC-1:0]   bus_wdata,
  output logic [NUM_SRC-1:0]   bus_rdata,
  output logic                 irq_valid,
  output logic [VEC_W-1:0]     irq_vector,
  input  logic                 irq_ack
);
  logic [NUM_EXT-1:0] ext_edge_q, pin_fn_q, ext_pulse;
  logic [1:0]         aux_mode_q;
  logic               aux_src_q, aux_in, aux_pulse;
  src_vec_t           src_en_q, set_v, flags;
  logic               mask_q, win_found;
  logic [IDX_W-1:0]   win_idx;
  logic               take;

  assign take = irq_valid & irq_ack;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_edge_q <= '0;
      aux_mode_q <= '0;
      aux_src_q  <= 1'b0;
      pin_fn_q   <= '0;
      src_en_q   <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        3'd0: begin
          ext_edge_q <= bus_wdata[NUM_EXT-1:0];
          aux_mode_q <= bus_wdata[NUM_EXT+1:NUM_EXT];
          aux_src_q  <= bus_wdata[NUM_EXT+2];
        end
        3'd1:    pin_fn_q <= bus_wdata[NUM_EXT-1:0];
        3'd2:    src_en_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  // global mask: acknowledge wins over a software write
  always_ff @(posedge clk) begin
    if (!rst_n)                        mask_q <= 1'b1;
    else if (take)                     mask_q <= 1'b1;
    else if (bus_we && bus_addr == 3'd4) mask_q <= bus_wdata[0];
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = NUM_SRC'({aux_src_q, aux_mode_q, ext_edge_q});
      3'd1:    bus_rdata = NUM_SRC'(pin_fn_q);
      3'd2:    bus_rdata = src_en_q;
      3'd3:    bus_rdata = flags;
      3'd4:    bus_rdata = NUM_SRC'(mask_q);
      default: bus_rdata = '0;
    endcase
  end

  // edge detectors
  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    irq_edge_sense #(.STAGES(SYNC_STAGES)) i_edge (
      .clk(clk), .rst_n(rst_n), .din(ext_pin[g]),
      .mode({1'b0, ext_edge_q[g]}), .pulse(ext_pulse[g]));
  end

  assign aux_in = aux_src_q ? aux_pwm : aux_pin;

  irq_edge_sense #(.STAGES(SYNC_STAGES)) i_aux_edge (
    .clk(clk), .rst_n(rst_n), .din(aux_in), .mode(aux_mode_q), .pulse(aux_pulse));

  always_comb begin
    set_v = '0;
    for (int i = 0; i < NUM_EXT; i++)
      set_v[ext_to_src(i)] = ext_pulse[i] & pin_fn_q[i];
    set_v[AUX_IDX] = aux_pulse & src_en_q[AUX_IDX];
    for (int j = 0; j < NUM_INT; j++)
      set_v[INT_BASE + j] = periph_req[j];
  end

  irq_flag_bank i_flags (
    .clk(clk), .rst_n(rst_n), .set(set_v),
    .wr_en(bus_we && bus_addr == 3'd3), .wr_data(bus_wdata), .flags(flags));

  irq_arbiter i_arb (.req(flags & src_en_q), .found(win_found), .idx(win_idx));

  // output stage: held until acknowledged
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else if (irq_valid) begin
      if (irq_ack) irq_valid <= 1'b0;
    end else if (win_found && !mask_q) begin
      irq_valid  <= 1'b1;
      irq_vector <= vec_of(win_idx);
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_vector)));
  p_ack_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (mask_q && !irq_valid));
  p_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(!mask_q));
  p_vec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector >= 5'd4 && irq_vector <= 5'd20 &&
                   irq_vector != 5'd9 && irq_vector != 5'd10 && irq_vector != 5'd17));
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  ext_pin = '0;
  logic        aux_pin = 1'b0, aux_pwm = 1'b0;
  logic [8:0]  periph_req = '0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [13:0] bus_wdata = '0;
  logic [13:0] bus_rdata;
  logic        irq_valid, irq_ack = 1'b0;
  logic [4:0]  irq_vector;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [13:0] rd;

  irq_vector_ctrl i_irq_vector_ctrl (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // {source index, expected vector}
  localparam logic [8:0] TBL [14] = '{
    {4'd0, 5'd4},  {4'd1, 5'd5},  {4'd2, 5'd6},  {4'd3, 5'd7},
    {4'd4, 5'd8},  {4'd5, 5'd11}, {4'd6, 5'd12}, {4'd7, 5'd13},
    {4'd8, 5'd14}, {4'd9, 5'd15}, {4'd10, 5'd16}, {4'd11, 5'd18},
    {4'd12, 5'd19}, {4'd13, 5'd20}};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [13:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdr(input logic [2:0] a, output logic [13:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic pulse_req(input int j);
    @(negedge clk); periph_req[j] = 1'b1;
    @(negedge clk); periph_req[j] = 1'b0;
  endtask

  task automatic drive_src(input int idx, input logic v);
    case (idx)
      0: ext_pin[0] = v;
      1: ext_pin[1] = v;
      2: aux_pin = v;
      3: ext_pin[2] = v;
      4: ext_pin[3] = v;
      default: if (v) pulse_req(idx - 5);
    endcase
  endtask

  task automatic clear_unmask();
    wr(3'd3, 14'h0);
    wr(3'd4, 14'h1 ^ 14'h1);
  endtask

  initial begin
    wt(3); rst_n = 1'b1; wt(1);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rdr(3'(a), rd);
      chk("R1 reg", int'(rd), (a == 4) ? 1 : 0);
    end
    chk("R1 valid", int'(irq_valid), 0);

    // common setup: rising edges on pins and aux, all enabled, unmasked
    wr(3'd0, 14'h1F); wr(3'd1, 14'hF); wr(3'd2, 14'h3FFF); wr(3'd4, 14'h0);

    // R8 vector per source, R9 ack behaviour
    for (int k = 0; k < 14; k++) begin
      int idx, vec;
      idx = int'(TBL[k][8:5]); vec = int'(TBL[k][4:0]);
      @(negedge clk); drive_src(idx, 1'b1);
      wt(6);
      chk("R8 valid", int'(irq_valid), 1);
      chk("R8 vector", int'(irq_vector), vec);
      rdr(3'd3, rd); chk("R6 flag pos", int'(rd), 1 << idx);
      ack();
      chk("R9 valid drop", int'(irq_valid), 0);
      rdr(3'd4, rd); chk("R9 mask set", int'(rd), 1);
      rdr(3'd3, rd); chk("R9 flag kept", int'(rd), 1 << idx);
      @(negedge clk); drive_src(idx, 1'b0);
      wt(6);
      clear_unmask(); wt(3);
      chk("R9 no re-offer", int'(irq_valid), 0);
    end

    // R2 falling edge select (masked)
    wr(3'd4, 14'h1); wr(3'd0, 14'h1E);
    @(negedge clk); ext_pin[0] = 1'b1; wt(6);
    rdr(3'd3, rd); chk("R2 rise ignored", int'(rd), 0);
    ext_pin[0] = 1'b0; wt(6);
    rdr(3'd3, rd); chk("R2 fall sets", int'(rd), 1);
    wr(3'd3, 14'h0); wr(3'd0, 14'h1F);

    // R2 pin function disabled
    wr(3'd1, 14'hE);
    @(negedge clk); ext_pin[0] = 1'b1; wt(6);
    rdr(3'd3, rd); chk("R2 pin fn off", int'(rd), 0);
    ext_pin[0] = 1'b0; wt(6); wr(3'd1, 14'hF);

    // R3 both edges, then falling only
    wr(3'd0, 14'h2F);
    @(negedge clk); aux_pin = 1'b1; wt(6);
    rdr(3'd3, rd); chk("R3 both rise", int'(rd), 4);
    wr(3'd3, 14'h0);
    aux_pin = 1'b0; wt(6);
    rdr(3'd3, rd); chk("R3 both fall", int'(rd), 4);
    wr(3'd3, 14'h0); wr(3'd0, 14'h0F);
    @(negedge clk); aux_pin = 1'b1; wt(6);
    rdr(3'd3, rd); chk("R3 fall mode rise", int'(rd), 0);
    aux_pin = 1'b0; wt(6);
    rdr(3'd3, rd); chk("R3 fall mode fall", int'(rd), 4);
    wr(3'd3, 14'h0); wr(3'd0, 14'h1F);

    // R3 aux enable off blocks the flag
    wr(3'd2, 14'h3FFB);
    @(negedge clk); aux_pin = 1'b1; wt(6);
    rdr(3'd3, rd); chk("R3 aux disabled", int'(rd), 0);
    aux_pin = 1'b0; wt(6); wr(3'd2, 14'h3FFF);

    // R4 PWM as aux source
    wr(3'd0, 14'h5F);
    @(negedge clk); aux_pin = 1'b1; wt(6);
    rdr(3'd3, rd); chk("R4 pin ignored", int'(rd), 0);
    aux_pin = 1'b0; aux_pwm = 1'b1; wt(6);
    rdr(3'd3, rd); chk("R4 pwm sets", int'(rd), 4);
    aux_pwm = 1'b0; wt(6); wr(3'd3, 14'h0); wr(3'd0, 14'h1F);

    // R5 and R6: write 1 has no effect
    pulse_req(0); wt(2);
    rdr(3'd3, rd); chk("R5 req sets", int'(rd), 32);
    wr(3'd3, 14'h3FFF);
    rdr(3'd3, rd); chk("R6 write one", int'(rd), 32);
    wr(3'd3, 14'h0);
    rdr(3'd3, rd); chk("R6 write zero", int'(rd), 0);

    // R6 set wins over clear
    @(negedge clk); periph_req[1] = 1'b1;
    wr(3'd3, 14'h0);
    rdr(3'd3, rd); chk("R6 set wins", int'(rd), 64);
    periph_req[1] = 1'b0; wr(3'd3, 14'h0);

    // R7 enable gating
    wr(3'd2, 14'h3FDF); wr(3'd4, 14'h0);
    pulse_req(0); wt(4);
    chk("R7 disabled", int'(irq_valid), 0);
    wr(3'd2, 14'h3FFF); wt(1);
    chk("R7 enabled valid", int'(irq_valid), 1);
    chk("R7 enabled vec", int'(irq_vector), 11);
    ack(); clear_unmask();

    // R7 mask, R9 hold while flag cleared
    wr(3'd4, 14'h1);
    pulse_req(8); wt(4);
    chk("R7 masked", int'(irq_valid), 0);
    wr(3'd4, 14'h0); wt(1);
    chk("R7 unmasked vec", int'(irq_vector), 20);
    wr(3'd3, 14'h0); wt(3);
    chk("R9 hold valid", int'(irq_valid), 1);
    chk("R9 hold vec", int'(irq_vector), 20);
    ack(); clear_unmask();

    // R8 priority among three pending
    wr(3'd4, 14'h1);
    pulse_req(8); pulse_req(2);
    @(negedge clk); ext_pin[3] = 1'b1; wt(6);
    wr(3'd4, 14'h0); wt(2);
    chk("R8 prio first", int'(irq_vector), 8);
    ack(); wr(3'd3, ~14'h0010); wr(3'd4, 14'h0); wt(2);
    chk("R8 prio second", int'(irq_vector), 13);
    ack(); wr(3'd3, ~14'h0090); wr(3'd4, 14'h0); wt(2);
    chk("R8 prio third", int'(irq_vector), 20);
    ack(); ext_pin[3] = 1'b0; wt(6); clear_unmask(); wt(2);
    chk("R8 none left", int'(irq_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule